// File: doc/BRIEF.md
# Fixed-Priority Pending Interrupt Controller

This block gathers interrupt requests from four sources into a sticky pending register. A request that is high at a clock edge sets that source's pending bit, and the bit stays set until the source is retired or the block is reset. The pending bits are ANDed with a per-source enable mask. The controller then presents the lowest-numbered active source as a valid flag and a binary source number.

A one-cycle acknowledge strobe retires only the source presented in the cycle the strobe is sampled. Disabling a source hides its pending bit without clearing it. The pending register is the only state in the block. The valid flag and source number follow the enable input within the same cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every pending bit, whatever the request and acknowledge inputs are in that cycle.
- R2: When several sources are active (pending AND enabled), `irq_id` is the binary index of the lowest-numbered active source. Source 0 has the highest priority and source 3 the lowest.
- R3: A request bit high at one clock edge sets the pending bit of that source. The bit stays set after the request drops, until it is acknowledged or reset.
- R4: A source whose enable bit is 0 keeps its pending bit but is not presented. Setting the enable bit again presents it with no new request.
- R5: When `irq_ack` is high at an edge and a source is presented, only that source's pending bit is cleared. The presented source is chosen from the pending state before the edge and the enable mask of that cycle.
- R6: When `irq_ack` is high and no source is presented, the pending state is not cleared. Requests in the same cycle are still captured.
- R7: If the presented source is acknowledged and requested in the same cycle, it stays pending.
- R8: A request on a source that is already pending has no further effect: one acknowledge retires it.
- R9: When no source is active, `irq_valid` is 0 and `irq_id` is 0.
- R10: `irq_valid` and `irq_id` are combinational from the pending register and the current `irq_en`. A change of the mask shows on the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 4 | Level request per source; bit i is source i |
| irq_en | input | 4 | Enable mask per source; bit i is source i |
| irq_ack | input | 1 | Acknowledge strobe that retires the presented source |
| irq_valid | output | 1 | High when at least one enabled source is pending |
| irq_id | output | 2 | Binary index of the presented source, 0 when none |

## Verification
The pending register is the only state. A wrong bit in it shows at the ports no later than the cycle in which that source becomes the lowest enabled pending one. The bench opens each source in turn through the mask, so a stuck or lost bit is exposed within a few cycles. A wrong clear on acknowledge shows in the very next cycle as a wrong `irq_valid` or `irq_id`, because the bench compares both after every edge against a reference model of the pending vector. A fault in the mask path shows within the same cycle, before any edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned IRQ_SRC_DEF = 4;

    function automatic int unsigned id_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned N    = irq_pkg::IRQ_SRC_DEF,
    parameter int unsigned ID_W = irq_pkg::id_width(N)
) (
    input  logic [N-1:0]    active,
    output logic            any_o,
    output logic [ID_W-1:0] id_o,
    output logic [N-1:0]    grant_o
);
    // Scan from the lowest priority up so the lowest index wins last.
    always_comb begin
        any_o   = 1'b0;
        id_o    = '0;
        grant_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (active[i]) begin
                any_o   = 1'b1;
                id_o    = ID_W'(i);
                grant_o = N'(1) << i;
            end
        end
    end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int unsigned N = irq_pkg::IRQ_SRC_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pend = '0;
        end else begin
            // Clear first, then OR in requests so a re-request survives.
            st_d.pend = (st_q.pend & ~clr_i) | set_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> pend_o == '0);

    // R3
    req_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_o & ~$past(clr_i) & $past(pend_o)) == ($past(pend_o) & ~$past(clr_i))));

    // R5
    clear_single_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(clr_i) <= 1);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int unsigned N    = irq_pkg::IRQ_SRC_DEF,
    parameter int unsigned ID_W = irq_pkg::id_width(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    irq_req,
    input  logic [N-1:0]    irq_en,
    input  logic            irq_ack,
    output logic            irq_valid,
    output logic [ID_W-1:0] irq_id
);
    logic [N-1:0] pend_q;
    logic [N-1:0] active;
    logic [N-1:0] grant;
    logic [N-1:0] clr_vec;

    assign active = pend_q & irq_en;

    irq_prio_pick #(.N(N), .ID_W(ID_W)) pick_i (
        .active  (active),
        .any_o   (irq_valid),
        .id_o    (irq_id),
        .grant_o (grant)
    );

    assign clr_vec = (irq_ack && irq_valid) ? grant : '0;

    irq_pend_reg #(.N(N)) pend_i (
        .clk    (clk),
        .rst    (rst),
        .set_i  (irq_req),
        .clr_i  (clr_vec),
        .pend_o (pend_q)
    );

    // R2
    lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (active[irq_id] && ((active & ((N'(1) << irq_id) - N'(1))) == '0)));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_valid |-> (irq_id == '0 && active == '0));

    // R5
    ack_retire_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_valid && !irq_req[irq_id]) |=> !pend_q[$past(irq_id)]);

    // R7
    ack_rereq_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_valid && irq_req[irq_id]) |=> pend_q[$past(irq_id)]);

    // R6
    idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !irq_valid) |=> pend_q == ($past(pend_q) | $past(irq_req)));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns / 1ps
module prio_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] irq_req;
    logic [3:0] irq_en;
    logic       irq_ack;
    logic       irq_valid;
    logic [1:0] irq_id;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] mdl_pend = 4'b0;
    logic [2:0] exp_q[$];
    string      tag_q[$];
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_en(irq_en),
        .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_id(irq_id)
    );

    function automatic logic [2:0] pick(input logic [3:0] p, input logic [3:0] e);
        logic [3:0] a = p & e;
        for (int i = 0; i < 4; i++)
            if (a[i]) return {1'b1, 2'(i)};
        return 3'b000;
    endfunction

    function automatic void compare(input string tag, input logic [2:0] exp);
        n_tests++;
        if (irq_valid !== exp[2] || (exp[2] && irq_id !== exp[1:0])) begin
            n_fail++;
            $display("FAIL %s: valid/id got %b/%0d expected %b/%0d",
                     tag, irq_valid, irq_id, exp[2], exp[1:0]);
        end
    endfunction

    // Driver: apply one cycle of stimulus, push the outcome expected after the edge.
    task automatic step(input string tag, input logic r, input logic [3:0] rq,
                        input logic [3:0] en, input logic ak);
        logic [2:0] pre;
        logic [3:0] nxt;
        @(negedge clk);
        rst = r; irq_req = rq; irq_en = en; irq_ack = ak;
        pre = pick(mdl_pend, en);
        if (r) nxt = 4'b0;
        else begin
            nxt = mdl_pend;
            if (ak && pre[2]) nxt[pre[1:0]] = 1'b0;
            nxt = nxt | rq;
        end
        mdl_pend = nxt;
        exp_q.push_back(pick(nxt, en));
        tag_q.push_back(tag);
    endtask

    // Mask change with no edge in between: outputs must follow at once.
    task automatic mask_now(input string tag, input logic [3:0] en);
        @(negedge clk);
        irq_req = 4'b0; irq_ack = 1'b0; rst = 1'b0; irq_en = en;
        #1 compare(tag, pick(mdl_pend, en));
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() != 0) compare(tag_q.pop_front(), exp_q.pop_front());
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: got hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_req = 4'b0; irq_en = 4'b0; irq_ack = 1'b0;
        step("R1 reset", 1, 4'b0000, 4'b1111, 0);
        step("R1 reset overrides req/ack", 1, 4'b1010, 4'b1111, 1);
        step("R9 idle masked", 0, 4'b0000, 4'b0000, 0);
        step("R9 idle enabled", 0, 4'b0000, 4'b1111, 0);
        for (int s = 0; s < 4; s++) begin
            step("R3 single req", 0, 4'(1 << s), 4'b1111, 0);
            step("R3 sticky after drop", 0, 4'b0000, 4'b1111, 0);
            step("R5 ack single", 0, 4'b0000, 4'b1111, 1);
        end
        step("R2 all req", 0, 4'b1111, 4'b1111, 0);
        step("R2 ack 0", 0, 4'b0000, 4'b1111, 1);
        step("R2 ack 1", 0, 4'b0000, 4'b1111, 1);
        step("R2 ack 2", 0, 4'b0000, 4'b1111, 1);
        step("R2 ack 3", 0, 4'b0000, 4'b1111, 1);
        step("R4 req while masked", 0, 4'b0100, 4'b0000, 0);
        step("R4 still hidden", 0, 4'b0000, 4'b0000, 0);
        step("R4 reenable shows", 0, 4'b0000, 4'b1111, 0);
        step("R4 clear", 0, 4'b0000, 4'b1111, 1);
        step("R10 seed 1,3", 0, 4'b1010, 4'b1111, 0);
        mask_now("R10 only 3 same cycle", 4'b1000);
        mask_now("R10 only 1 same cycle", 4'b0010);
        mask_now("R10 none same cycle", 4'b0000);
        step("R5 ack picks masked view (3)", 0, 4'b0000, 4'b1000, 1);
        step("R5 source 1 kept", 0, 4'b0000, 4'b1111, 0);
        step("R5 ack 1", 0, 4'b0000, 4'b1111, 1);
        step("R6 ack with nothing", 0, 4'b0000, 4'b1111, 1);
        step("R6 ack idle captures req", 0, 4'b0100, 4'b1111, 1);
        step("R6 captured persists", 0, 4'b0000, 4'b1111, 0);
        step("R6 clear", 0, 4'b0000, 4'b1111, 1);
        step("R6 masked-pending not cleared", 0, 4'b0001, 4'b0000, 0);
        step("R6 ack masked", 0, 4'b0000, 4'b0000, 1);
        step("R6 reveal", 0, 4'b0000, 4'b1111, 0);
        step("R7 ack+rereq same src", 0, 4'b0001, 4'b1111, 1);
        step("R7 still pending", 0, 4'b0000, 4'b1111, 0);
        step("R7 final ack", 0, 4'b0000, 4'b1111, 1);
        step("R5 seed 1", 0, 4'b0010, 4'b1111, 0);
        step("R5 ack 1 with req 3", 0, 4'b1000, 4'b1111, 1);
        step("R5 ack 3", 0, 4'b0000, 4'b1111, 1);
        step("R8 seed 3", 0, 4'b1000, 4'b1111, 0);
        step("R8 repeat 3", 0, 4'b1000, 4'b1111, 0);
        step("R8 one ack retires", 0, 4'b0000, 4'b1111, 1);
        step("R1 seed", 0, 4'b0110, 4'b1111, 0);
        step("R1 mid reset", 1, 4'b0000, 4'b1111, 0);
        step("R1 after release", 0, 4'b0000, 4'b1111, 0);
        for (int k = 0; k < 300; k++)
            step("R2 random", 0, 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                 1'($urandom_range(0, 1)));
        @(negedge clk);
        irq_req = 4'b0; irq_ack = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule